// File: doc/BRIEF.md
# Sequential Cartridge Read-Ahead Buffer

This block sits between a CPU read port and a slow, read-only cartridge port that is 16 bits wide. Every cartridge read takes a programmable number of wait cycles. The block keeps a short queue of halfwords that the CPU has not asked for yet. After any CPU cartridge read, it fetches the following consecutive halfwords in the background, but only in cycles when the CPU is not requesting the cartridge. It holds at most eight of these entries.

When the CPU next asks for the address at the head of the queue, the block answers in the same cycle and drops that entry. Any other address empties the queue and runs a normal cartridge access using the first-access wait count. Read-ahead then starts again from the halfword after that address. The unit is a stream buffer and not a cache: it has no tags, and it only knows the address of its head entry.

Top module: `cart_prefetch`

## Requirements
- R1: After reset, cpu_ready and cart_req are low, the queue is empty, and no read-ahead is issued until the CPU makes its first cartridge read.
- R2: A CPU read that misses while the cartridge port is idle raises cart_req in the next cycle. cart_req stays high for first_wait+1 cycles, with cart_addr equal to the requested address. cpu_ready pulses in the last of those cycles, with cpu_rdata equal to cart_rdata. The request therefore completes in first_wait+2 cycles.
- R3: Address bit 0 is ignored. cart_addr bit 0 is always zero, and a CPU address that differs from the head address only in bit 0 is a hit returning the head data.
- R4: After a CPU access at address A, read-ahead fetches A+2, A+4, and so on in order. Each fetch holds cart_req for seq_wait+1 cycles. A fetch is started only in a cycle where cpu_req is low.
- R5: A CPU read whose address matches the head entry completes in one cycle (cpu_ready in the request cycle), returns that entry's data and starts no cartridge access.
- R6: The queue never holds more than eight entries. When it is full, read-ahead stops until an entry is consumed.
- R7: A non-matching CPU read flushes every entry, so an address that was buffered before the flush is a miss afterwards.
- R8: A read-ahead fetch already in flight when the CPU requests finishes first, delaying the CPU request only by its remaining cycles. If the fetched entry matches the request, the request hits in the cycle after the fetch completes.
- R9: While the CPU requests the cartridge in every cycle, no read-ahead fetch is issued and the buffer gives no speedup once it runs empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_wait | input | WW | Wait cycles for a CPU miss access |
| seq_wait | input | WW | Wait cycles for a read-ahead fetch |
| cpu_req | input | 1 | CPU cartridge read request, held until cpu_ready |
| cpu_addr | input | AW | CPU byte address (bit 0 ignored) |
| cpu_ready | output | 1 | Read completes this cycle |
| cpu_rdata | output | DW | Read data, valid with cpu_ready |
| cart_req | output | 1 | Cartridge access in progress |
| cart_addr | output | AW | Cartridge halfword address, bit 0 zero |
| cart_rdata | input | DW | Cartridge data, captured in the last access cycle |

## Verification
The bench uses a fixed first-access wait and a fixed sequential wait, then goes after four timing corners.

- A CPU request that lands while a read-ahead fetch is mid-access must wait out exactly the remaining cycles. A design that aborted the fetch, or started the miss too early, would give a different cycle count or drive the wrong cart_addr.
- A fetch that completes exactly the entry the CPU is waiting for must turn the stall into a hit. A design that treated it as a miss would spend a full first-access delay.
- After a flush, an address that had been buffered must miss. A design that kept stale entries would answer in one cycle.
- With back-to-back requests, the cartridge must see no fetch at all. Once the queue is empty, the next read must cost a full miss.

The bench also counts fetches after a miss, which exposes a queue that overfills past eight. It checks that bit 0 never reaches the cartridge.

// File: rtl/cart_prefetch.sv
module cart_prefetch #(
  parameter int AW    = 25,
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int WW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] first_wait,
  input  logic [WW-1:0] seq_wait,
  input  logic          cpu_req,
  input  logic [AW-1:0] cpu_addr,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          cart_req,
  output logic [AW-1:0] cart_addr,
  input  logic [DW-1:0] cart_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          busy, is_cpu, pf_on;
  logic [WW-1:0] cnt;
  logic [AW-1:0] cur_addr, pf_addr, head_addr;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic [DW-1:0] mem [DEPTH];

  logic [AW-1:0] req_addr;
  logic last, hit, start_miss, start_pf, push, cpu_done;

  assign req_addr   = {cpu_addr[AW-1:1], 1'b0};
  assign last       = busy && (cnt == '0);
  assign cpu_done   = last && is_cpu;
  assign push       = last && !is_cpu;
  assign hit        = cpu_req && (count != '0) && (req_addr == head_addr) && !(busy && is_cpu);
  assign start_miss = cpu_req && !busy && !hit;
  assign start_pf   = !cpu_req && !busy && pf_on && (count < CW'(DEPTH));

  assign cart_req  = busy;
  assign cart_addr = cur_addr;
  assign cpu_ready = hit || cpu_done;
  assign cpu_rdata = hit ? mem[rd_ptr] : cart_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      is_cpu    <= 1'b0;
      pf_on     <= 1'b0;
      cnt       <= '0;
      cur_addr  <= '0;
      pf_addr   <= '0;
      head_addr <= '0;
    end else begin
      if (start_miss) begin
        busy     <= 1'b1;
        is_cpu   <= 1'b1;
        cnt      <= first_wait;
        cur_addr <= req_addr;
      end else if (start_pf) begin
        busy     <= 1'b1;
        is_cpu   <= 1'b0;
        cnt      <= seq_wait;
        cur_addr <= pf_addr;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
      if (cpu_done) begin
        pf_on     <= 1'b1;
        pf_addr   <= cur_addr + AW'(2);
        head_addr <= cur_addr + AW'(2);
      end else begin
        if (push) pf_addr <= cur_addr + AW'(2);
        if (hit)  head_addr <= head_addr + AW'(2);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (start_miss) begin
      rd_ptr <= wr_ptr;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (hit)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push) - CW'(hit);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= cart_rdata;
  end

  a_r3_halfword: assert property (@(posedge clk) disable iff (!rst_n)
    cart_req |-> !cart_addr[0]);

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(cnt) != '0) |-> $stable(cart_addr));

  a_r5_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r7_empty_during_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && is_cpu) |-> (count == '0));

  a_r9_no_fetch_under_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_cpu && !$past(busy)) |-> !$past(cpu_req));
endmodule

// File: tb/tb_cart_prefetch.sv
module tb_cart_prefetch;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 25;
  localparam int DW = 16;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WW-1:0] first_wait = 4'd3;
  logic [WW-1:0] seq_wait = 4'd1;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready, cart_req;
  logic [DW-1:0] cpu_rdata, cart_rdata;
  logic [AW-1:0] cart_addr;

  int checks = 0, errors = 0;
  int rises = 0, cur_len = 0, first_len = 0;
  logic [AW-1:0] last_rise_addr = '0;
  logic prev_req = 1'b0, odd_seen = 1'b0;
  int rcyc;
  logic [DW-1:0] rdat;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_prefetch #(.AW(AW), .DW(DW), .DEPTH(8), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .first_wait(first_wait), .seq_wait(seq_wait),
    .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .cart_req(cart_req), .cart_addr(cart_addr),
    .cart_rdata(cart_rdata));

  function automatic logic [DW-1:0] romval(input logic [AW-1:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction

  assign cart_rdata = romval(cart_addr);

  always @(negedge clk) begin
    if (cart_req && cart_addr[0]) odd_seen <= 1'b1;
    if (cart_req && !prev_req) begin
      rises <= rises + 1;
      last_rise_addr <= cart_addr;
      cur_len <= 1;
    end else if (cart_req) begin
      cur_len <= cur_len + 1;
    end else if (prev_req && first_len == 0) begin
      first_len <= cur_len;
    end
    prev_req <= cart_req;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic cpu_read(input logic [AW-1:0] a);
    cpu_req = 1'b1;
    cpu_addr = a;
    rcyc = 1;
    forever begin
      @(negedge clk);
      if (cpu_ready) break;
      @(posedge clk);
      #1;
      rcyc++;
      if (rcyc > 100) break;
    end
    rdat = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!cpu_ready, "R1 ready low", cpu_ready, 0);
    check(!cart_req, "R1 cart_req low", cart_req, 0);
    rises = 0;
    idle(20);
    check(rises == 0, "R1 no read-ahead before first read", rises, 0);
  endtask

  task automatic t_first_miss();
    cpu_read(25'h100);
    check(rcyc == 5, "R2 miss latency", rcyc, 5);
    check(rdat == romval(25'h100), "R2 miss data", rdat, romval(25'h100));
    rises = 0;
    idle(30);
    check(rises == 8, "R6 fill stops at eight", rises, 8);
    check(last_rise_addr == 25'h110, "R4 sequential addresses", last_rise_addr, 25'h110);
  endtask

  task automatic t_hits_back_to_back();
    rises = 0;
    for (int i = 1; i <= 8; i++) begin
      cpu_read(25'h100 + AW'(2*i));
      check(rcyc == 1, "R5 hit in one cycle", rcyc, 1);
      check(rdat == romval(25'h100 + AW'(2*i)), "R5 hit data", rdat, romval(25'h100 + AW'(2*i)));
    end
    check(rises == 0, "R9 no fetch under continuous requests", rises, 0);
    cpu_read(25'h112);
    check(rcyc == 5, "R9 empty buffer gives full miss", rcyc, 5);
  endtask

  task automatic t_flush_and_stall();
    idle(30);
    cpu_read(25'h300);
    check(rcyc == 5, "R7 non-matching read misses", rcyc, 5);
    idle(1);
    cpu_read(25'h114);
    check(rcyc == 7, "R7 R8 flushed entry misses after in-flight fetch", rcyc, 7);
    check(rdat == romval(25'h114), "R7 miss data", rdat, romval(25'h114));
  endtask

  task automatic t_inflight_hit();
    idle(1);
    cpu_read(25'h116);
    check(rcyc == 3, "R8 completed fetch hits", rcyc, 3);
    check(rdat == romval(25'h116), "R8 data", rdat, romval(25'h116));
  endtask

  task automatic t_odd_address();
    idle(30);
    cpu_read(25'h119);
    check(rcyc == 1, "R3 bit0 ignored hit", rcyc, 1);
    check(rdat == romval(25'h118), "R3 head data", rdat, romval(25'h118));
  endtask

  task automatic t_wait_counts();
    idle(10);
    first_wait = 4'd0;
    seq_wait = 4'd3;
    cpu_read(25'h400);
    check(rcyc == 2, "R2 zero first wait", rcyc, 2);
    check(rdat == romval(25'h400), "R2 data", rdat, romval(25'h400));
    idle(1);
    first_len = 0;
    idle(10);
    check(first_len == 4, "R4 sequential wait length", first_len, 4);
    check(!odd_seen, "R3 cart_addr bit0 zero", odd_seen, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_first_miss();
    t_hits_back_to_back();
    t_flush_and_stall();
    t_inflight_hit();
    t_odd_address();
    t_wait_counts();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule